// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block counts events on a slow external count clock and presents the count as ten one-hot decoded lines plus a carry. The count lives in a five-stage twisted-ring (Johnson) register. The register shifts its own inverted last stage back into its first stage, so it walks through ten states. Each decoded line is formed from one adjacent pair of stages. Only one stage changes per step, so no decoded line can pulse on its way between two states.

The whole block runs on a fast system clock. Both the count clock and its active-low enable pass through synchronizers, then the enable gates the count clock. A count event is a low-to-high change of that gated level. Counting therefore also happens when the enable falls while the count clock is already high.

The carry is high for the lower half of the cycle and low for the upper half. Its rising edge, at the wrap from nine to zero, can drive the count clock of the next counter in a chain. A synchronous reset returns the count to zero. A correction term in the ring feedback steers any non-sequence pattern back into the ten-state cycle.

Top module: `johnson_decade`

## Requirements
- R1: Each count event moves the active decoded line from index n to index (n+1) mod 10, so ten events bring the outputs back to where they started.
- R2: While the ring holds a sequence state, exactly one bit of `dec_o` is high, and `dec_o[n]` is high only while the count equals n.
- R3: An input change that creates a count event shows on `dec_o` after the third rising system-clock edge that follows it: two synchronizer stages, then the count register.
- R4: With `cnt_en_n_i` high, toggling `cnt_clk_i` leaves the count unchanged, and with `cnt_clk_i` low the count also holds.
- R5: A falling `cnt_en_n_i` while `cnt_clk_i` is high advances the count by one. A rising `cnt_en_n_i` while `cnt_clk_i` is high does not.
- R6: `rst` high forces the count to zero (`dec_o` = 10'b00_0000_0001, `carry_o` = 1) whatever the count inputs do. A count clock held high across the release of reset does not count.
- R7: `carry_o` is 1 for counts 0 to 4 and 0 for counts 5 to 9. It rises only on the step from 9 to 0.
- R8: A gated count level held high for any number of system cycles gives exactly one advance.
- R9: From any of the 22 five-bit codes outside the ten-state sequence, the ring reaches a sequence state within 30 count events and then steps as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, forces count zero |
| cnt_clk_i | input | 1 | Asynchronous count clock; rising edges count |
| cnt_en_n_i | input | 1 | Asynchronous count enable, active low |
| dec_o | output | 10 | One-hot decoded count, bit n high at count n |
| carry_o | output | 1 | High for counts 0 to 4, low for 5 to 9 |

## Verification
A ring holding a non-sequence pattern shows at once as zero or several `dec_o` lines high, together with a carry that disagrees with the lower-half lines. A ring that skips or repeats a state shows on the first event after the fault as a `dec_o` that is not the rotated previous value. A broken edge detector shows within the four system cycles of one count pulse, as a missing step or a double step. The bench loads every non-sequence code into the ring under reset, then counts the events needed to reach a single-hot output.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
   // default geometry of the twisted ring and of the input synchronizers
   localparam int unsigned JDC_STAGES_DEF = 5;
   localparam int unsigned JDC_SYNC_DEF   = 2;
   // index of the stage whose feedback clears an isolated one
   localparam int unsigned JDC_FIX_BIT    = 2;

   // number of distinct states of a twisted ring of the given length
   function automatic int unsigned jdc_states(input int unsigned stages);
      return 2 * stages;
   endfunction
endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
   parameter int unsigned WIDTH = 2,
   parameter int unsigned DEPTH = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (DEPTH < 2) begin : g_depth_bad
         $error("jdc_sync: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_width_bad
         $error("jdc_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [DEPTH];

   // first stage captures the asynchronous inputs
   always_ff @(posedge clk) begin
      chain_q[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/jdc_edge.sv
module jdc_edge (
   input  logic clk,
   input  logic rst,
   input  logic cnt_clk_s,
   input  logic cnt_en_n_s,
   output logic adv_o
);
   logic gated;
   logic gated_prev_q;

   // the enable masks the count clock; a falling enable while the
   // clock is high therefore also raises the gated level
   assign gated = cnt_clk_s & ~cnt_en_n_s;

   // previous sample tracks the gated level even during reset, so a
   // level already high when reset ends is not taken as a new edge
   always_ff @(posedge clk) begin
      gated_prev_q <= gated;
   end

   assign adv_o = gated & ~gated_prev_q;

   // one event per low-to-high change of the gated level
   p_single_event_r8: assert property (@(posedge clk) disable iff (rst)
      adv_o |=> !adv_o);
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES = JDC_STAGES_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              adv_i,
   output logic [STAGES-1:0] stage_o
);
   generate
      if (STAGES < 3) begin : g_stages_bad
         $error("jdc_ring: STAGES must be at least 3");
      end
      if (JDC_FIX_BIT < 1 || JDC_FIX_BIT >= STAGES) begin : g_fix_bad
         $error("jdc_ring: correction stage out of range");
      end
   endgenerate

   localparam int unsigned FIX = JDC_FIX_BIT;

   logic [STAGES-1:0] stage_q;
   logic [STAGES-1:0] stage_nxt;

   // twisted feedback into stage 0, plain shift elsewhere; one stage
   // takes its neighbour only when that one is not isolated, which
   // wears an illegal pattern down to a single block of ones
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_next
         if (i == 0) begin : g_twist
            assign stage_nxt[i] = ~stage_q[STAGES-1];
         end else if (i == FIX) begin : g_fix
            assign stage_nxt[i] = stage_q[i-1] & (stage_q[i-2] | stage_q[i]);
         end else begin : g_shift
            assign stage_nxt[i] = stage_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q <= '0;
      end else if (adv_i) begin
         stage_q <= stage_nxt;
      end
   end

   assign stage_o = stage_q;

   // without an event the ring must not move
   p_hold_no_event_r4: assert property (@(posedge clk) disable iff (rst)
      !adv_i |=> $stable(stage_q));
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES = JDC_STAGES_DEF
) (
   input  logic                  [STAGES-1:0] stage_i,
   output logic [jdc_states(STAGES)-1:0]     dec_o,
   output logic                               carry_o
);
   localparam int unsigned NSTATES = jdc_states(STAGES);

   // every decode looks at one adjacent pair of stages only
   generate
      for (genvar k = 0; k < NSTATES; k++) begin : g_dec
         if (k == 0) begin : g_empty
            assign dec_o[k] = ~stage_i[STAGES-1] & ~stage_i[0];
         end else if (k < STAGES) begin : g_fill
            assign dec_o[k] = stage_i[k-1] & ~stage_i[k];
         end else if (k == STAGES) begin : g_full
            assign dec_o[k] = stage_i[STAGES-1] & stage_i[0];
         end else begin : g_drain
            assign dec_o[k] = ~stage_i[k-STAGES-1] & stage_i[k-STAGES];
         end
      end
   endgenerate

   // top stage is clear throughout the lower half of the cycle
   assign carry_o = ~stage_i[STAGES-1];
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
   import jdc_pkg::*;
#(
   parameter int unsigned STAGES     = JDC_STAGES_DEF,
   parameter int unsigned SYNC_DEPTH = JDC_SYNC_DEF
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          cnt_clk_i,
   input  logic                          cnt_en_n_i,
   output logic [jdc_states(STAGES)-1:0] dec_o,
   output logic                          carry_o
);
   localparam int unsigned NSTATES = jdc_states(STAGES);

   logic [1:0]        raw_in;
   logic [1:0]        sync_in;
   logic              adv;
   logic [STAGES-1:0] stage;

   assign raw_in = {cnt_clk_i, cnt_en_n_i};

   jdc_sync #(
      .WIDTH (2),
      .DEPTH (SYNC_DEPTH)
   ) sync_i (
      .clk (clk),
      .d_i (raw_in),
      .q_o (sync_in)
   );

   jdc_edge edge_i (
      .clk        (clk),
      .rst        (rst),
      .cnt_clk_s  (sync_in[1]),
      .cnt_en_n_s (sync_in[0]),
      .adv_o      (adv)
   );

   jdc_ring #(
      .STAGES (STAGES)
   ) ring_i (
      .clk     (clk),
      .rst     (rst),
      .adv_i   (adv),
      .stage_o (stage)
   );

   jdc_decode #(
      .STAGES (STAGES)
   ) dec_i (
      .stage_i (stage),
      .dec_o   (dec_o),
      .carry_o (carry_o)
   );

   // a legal one-hot state stays one-hot across any step
   p_onehot_kept_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot(dec_o) |=> $onehot(dec_o));

   // an event in a legal state rotates the active line up by one
   p_step_rotate_r1: assert property (@(posedge clk) disable iff (rst)
      (adv && $onehot(dec_o)) |=>
         (dec_o == {$past(dec_o[NSTATES-2:0]), $past(dec_o[NSTATES-1])}));

   // carry agrees with the lower half of the decoded lines
   p_carry_half_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot(dec_o) |-> (carry_o == (|dec_o[STAGES-1:0])));
endmodule

// File: tb/johnson_decade_tb_top.sv
module johnson_decade_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 24;
   localparam int RECOVER_MAX = 30;

   logic       clk = 1'b0;
   logic       rst;
   logic       cnt_clk;
   logic       cnt_en_n;
   logic [9:0] dec;
   logic       carry;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // vector: {count clock, enable_n, expected index[3:0]}
   localparam logic [5:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd1}, {1'b1, 1'b0, 4'd2}, {1'b0, 1'b0, 4'd2},
      {1'b0, 1'b1, 4'd2}, {1'b1, 1'b1, 4'd2}, {1'b0, 1'b1, 4'd2}, {1'b1, 1'b1, 4'd2},
      {1'b1, 1'b0, 4'd3}, {1'b1, 1'b1, 4'd3}, {1'b1, 1'b0, 4'd4}, {1'b0, 1'b0, 4'd4},
      {1'b1, 1'b0, 4'd5}, {1'b0, 1'b0, 4'd5}, {1'b1, 1'b0, 4'd6}, {1'b0, 1'b0, 4'd6},
      {1'b1, 1'b0, 4'd7}, {1'b0, 1'b0, 4'd7}, {1'b1, 1'b0, 4'd8}, {1'b0, 1'b0, 4'd8},
      {1'b1, 1'b0, 4'd9}, {1'b0, 1'b0, 4'd9}, {1'b1, 1'b0, 4'd0}, {1'b0, 1'b0, 4'd0}
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   johnson_decade dut_i (
      .clk        (clk),
      .rst        (rst),
      .cnt_clk_i  (cnt_clk),
      .cnt_en_n_i (cnt_en_n),
      .dec_o      (dec),
      .carry_o    (carry)
   );

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_idx(input int idx, input string req);
      logic [9:0] e;
      e = 10'b1 << idx;
      check(dec === e, req, {6'd0, dec}, {6'd0, e});
      check(carry === (idx < 5), {req, " carry"}, {15'd0, carry}, {15'd0, idx < 5});
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse();
      cnt_clk = 1'b1; wait_cyc(4);
      cnt_clk = 1'b0; wait_cyc(4);
   endtask

   task automatic do_reset();
      rst = 1'b1; cnt_clk = 1'b0; cnt_en_n = 1'b0;
      wait_cyc(4);
      rst = 1'b0;
      wait_cyc(2);
   endtask

   function automatic bit legal_code(input logic [4:0] c);
      for (int k = 0; k < 5; k++) begin
         logic [4:0] f;
         f = 5'((1 << k) - 1);
         if (c == f || c == (f ^ 5'h1f)) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic int idx_of(input logic [9:0] d);
      for (int k = 0; k < 10; k++) if (d[k]) return k;
      return 0;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      finish_run();
   end

   initial begin
      cnt_clk = 1'b0; cnt_en_n = 1'b0; rst = 1'b1;
      @(negedge clk);
      do_reset();
      // R6: reset state
      check_idx(0, "R6 reset state");

      // table walk: R1 stepping, R4 blocked clock, R5 enable edges, R7 carry
      for (int v = 0; v < NVEC; v++) begin
         cnt_clk  = VEC[v][5];
         cnt_en_n = VEC[v][4];
         wait_cyc(4);
         check_idx(int'(VEC[v][3:0]), $sformatf("R1/R4/R5 vector %0d", v));
      end

      // R3: latency of three system-clock edges
      begin
         cnt_clk = 1'b1;
         wait_cyc(2);
         check_idx(0, "R3 no change after two edges");
         wait_cyc(1);
         check_idx(1, "R3 change after third edge");
         cnt_clk = 1'b0; wait_cyc(4);
      end

      // R8: long high level counts once
      begin
         cnt_clk = 1'b1; wait_cyc(40);
         check_idx(2, "R8 single advance for long level");
         cnt_clk = 1'b0; wait_cyc(4);
         check_idx(2, "R8 no advance on falling level");
      end

      // R4: clock low with enable toggling holds
      begin
         cnt_en_n = 1'b1; wait_cyc(4); cnt_en_n = 1'b0; wait_cyc(4);
         check_idx(2, "R4 enable toggles with clock low");
      end

      // R1/R7: two full turns, carry rises only at the 9 to 0 wrap
      begin
         int exp_i;
         bit prev_c;
         exp_i = 2;
         for (int p = 0; p < 20; p++) begin
            prev_c = carry;
            pulse();
            exp_i = (exp_i + 1) % 10;
            check_idx(exp_i, "R1 full cycle step");
            check((carry && !prev_c) == (exp_i == 0), "R7 carry rise at wrap",
                  {15'd0, carry}, {15'd0, exp_i < 5});
         end
      end

      // R6: reset overrides running inputs; held clock at release does not count
      begin
         pulse(); pulse();
         rst = 1'b1;
         cnt_clk = 1'b1; wait_cyc(4);
         cnt_clk = 1'b0; wait_cyc(2);
         cnt_clk = 1'b1; wait_cyc(4);
         check_idx(0, "R6 reset overrides clock");
         rst = 1'b0; wait_cyc(8);
         check_idx(0, "R6 held clock across release");
         cnt_clk = 1'b0; wait_cyc(4);
         pulse();
         check_idx(1, "R6 counting resumes");
      end

      // R9: recovery from every non-sequence code
      for (int c = 0; c < 32; c++) begin
         if (!legal_code(5'(c))) begin
            int steps;
            int base;
            rst = 1'b1; cnt_clk = 1'b0; cnt_en_n = 1'b0;
            wait_cyc(4);
            force dut_i.ring_i.stage_q = 5'(c);
            wait_cyc(2);
            rst = 1'b0;
            wait_cyc(1);
            release dut_i.ring_i.stage_q;
            wait_cyc(1);
            steps = 0;
            while (!$onehot(dec) && steps <= RECOVER_MAX) begin
               pulse();
               steps++;
            end
            check(steps <= RECOVER_MAX, $sformatf("R9 recovery from code %0d", c),
                  16'(steps), 16'(RECOVER_MAX));
            base = idx_of(dec);
            for (int p = 1; p <= 10; p++) begin
               pulse();
               check_idx((base + p) % 10, $sformatf("R9 after recovery code %0d", c));
            end
         end
      end

      // R2: single-hot after a final reset and a few steps
      do_reset();
      for (int p = 0; p < 5; p++) begin
         pulse();
         check($countones(dec) == 1, "R2 exactly one line high",
               16'($countones(dec)), 16'd1);
      end

      finish_run();
   end
endmodule